// File: doc/BRIEF.md
# Two-Bank Sample Demultiplexer with Phase Alignment

The block accepts one conversion result on every rising edge of the sample clock. The result is built from an upper nibble and a lower nibble. The block delays it through a fixed pipeline and then writes it into one of two output bank registers, A or B. A mode pin selects between two steering schemes:

- **Single-channel:** every result lands in bank A.
- **Dual-channel:** results are dealt out alternately to A and B. Each bank then changes only on every second edge, so downstream logic can capture it at half the sample rate.

The steering phase in dual-channel mode is held in a toggle that flips on every captured sample. An alignment strobe, given as a true/complement pair, forces the sample captured on the same edge into bank A. The alternation then continues from that point.

When the mode pin changes, the block discards every sample still in flight and drops both bank valid flags. The flags return only when results captured under the new mode come out of the pipeline.

Top module: `sample_demux`

## Requirements
- R1: Each result is `{sample_hi_i, sample_lo_i}`, with the upper nibble in bits 7:4 of the bank output.
- R2: With `single_mode_i` = 1, each result is written to `bank_a_o`, and it is visible after the fourth rising edge following the edge that captured it.
- R3: With `single_mode_i` = 1, `bank_b_o` holds its last value and is never written.
- R4: With `single_mode_i` = 0, consecutive results go to bank A and bank B in alternation, and no edge writes both banks.
- R5: With `single_mode_i` = 0, a result is visible on its bank after the fifth rising edge following its capture edge.
- R6: An alignment strobe is recognised on an edge only when `sync_p_i` = 1 and `sync_n_i` = 0; the pairs 0/0, 1/1 and 0/1 are not strobes.
  - The sample captured on a strobe edge is steered to bank A.
  - The steering toggle flips on every captured sample, in either mode.
- R7: In dual-channel mode, a bank that is not written on an edge keeps its value, so each bank value stays on the outputs for two cycles.
- R8: While `rst_ni` is low, all outputs are 0. The pipeline is emptied and the toggle is cleared, so the first sample after reset is tagged for bank A.
- R9: A capture edge whose mode differs from the previous edge's mode does three things:
  - discards all earlier samples still in flight;
  - blocks any bank write on that edge;
  - clears both valid flags.
  Bank data registers keep their contents.
- R10: A bank's valid flag rises on the first write to that bank after reset or a flush, and it stays high until the next reset or flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock; every rising edge captures one result |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_hi_i | input | 4 | Upper nibble of the result |
| sample_lo_i | input | 4 | Lower nibble of the result |
| single_mode_i | input | 1 | 1 = single-channel, 0 = dual-channel |
| sync_p_i | input | 1 | Alignment strobe, true leg |
| sync_n_i | input | 1 | Alignment strobe, complement leg |
| bank_a_o | output | 8 | Bank A output register |
| bank_b_o | output | 8 | Bank B output register |
| valid_a_o | output | 1 | Bank A holds a result captured under the current mode |
| valid_b_o | output | 1 | Bank B holds a result captured under the current mode |

## Verification
An alignment strobe and a mode change can land on the same capture edge. On that edge the pipeline flush and the phase reset must both take effect, and the first sample of the new dual-channel run must still reach bank A five edges later, with no stale single-channel result slipping through. The bench drives this by switching from single to dual mode with the strobe asserted on that first dual edge. It also drives back-to-back strobes. A scoreboard model, built from the requirements, tracks both banks and both valid flags and compares them on every cycle.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  localparam int unsigned HALF_W = 4;
  localparam int unsigned DATA_W = 2 * HALF_W;

  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;

  typedef struct packed {
    logic              vld;
    logic              mode;   // 1 = single-channel
    bank_e             tag;
    logic [DATA_W-1:0] data;
  } stage_t;
endpackage

// File: rtl/sdm_steer.sv
module sdm_steer
  import sdm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sync_p_i,
  input  logic  sync_n_i,
  output logic  sync_o,
  output bank_e tag_o
);
  bank_e tog_q;

  always_comb begin
    sync_o = sync_p_i & ~sync_n_i;
    tag_o  = sync_o ? BANK_A : tog_q;
  end

  // flips on every captured sample, regardless of mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= BANK_A;
    else         tog_q <= (tag_o == BANK_A) ? BANK_B : BANK_A;
  end
endmodule

// File: rtl/sdm_pipe.sv
module sdm_pipe
  import sdm_pkg::*;
#(
  parameter int unsigned NSTG  = 5,
  parameter int unsigned TAP_S = 3,
  parameter int unsigned TAP_D = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  stage_t            entry_i,
  output logic              flush_o,
  output bank_e             head_tag_o,
  output logic              s_hit_o,
  output logic [DATA_W-1:0] s_data_o,
  output logic              d_hit_o,
  output bank_e             d_tag_o,
  output logic [DATA_W-1:0] d_data_o
);
  logic   mode_prev_q;
  stage_t stg_q [NSTG];

  assign flush_o = (entry_i.mode != mode_prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_prev_q <= 1'b1;
    else         mode_prev_q <= entry_i.mode;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSTG; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= entry_i;
      for (int i = 1; i < NSTG; i++) begin
        stg_q[i] <= stg_q[i-1];
        // samples from the previous mode are dropped
        if (flush_o) stg_q[i].vld <= 1'b0;
      end
    end
  end

  always_comb begin
    head_tag_o = stg_q[0].tag;
    s_hit_o    = stg_q[TAP_S].vld & stg_q[TAP_S].mode;
    s_data_o   = stg_q[TAP_S].data;
    d_hit_o    = stg_q[TAP_D].vld & ~stg_q[TAP_D].mode;
    d_tag_o    = stg_q[TAP_D].tag;
    d_data_o   = stg_q[TAP_D].data;
  end
endmodule

// File: rtl/sdm_bank.sv
module sdm_bank
  import sdm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              req_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else if (flush_i) begin
      valid_o <= 1'b0;
    end else if (req_i) begin
      data_o  <= data_i;
      valid_o <= 1'b1;
    end
  end

  AST_VALID_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !flush_i) |=> valid_o); // R10
endmodule

// File: rtl/sample_demux.sv
module sample_demux
  import sdm_pkg::*;
#(
  parameter int unsigned SINGLE_LAT = 4,
  parameter int unsigned DUAL_LAT   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] sample_hi_i,
  input  logic [HALF_W-1:0] sample_lo_i,
  input  logic              single_mode_i,
  input  logic              sync_p_i,
  input  logic              sync_n_i,
  output logic [DATA_W-1:0] bank_a_o,
  output logic [DATA_W-1:0] bank_b_o,
  output logic              valid_a_o,
  output logic              valid_b_o
);
  localparam int unsigned NSTG   = DUAL_LAT;
  localparam int unsigned TAP_S  = SINGLE_LAT - 1;
  localparam int unsigned TAP_D  = DUAL_LAT - 1;
  localparam int unsigned NBANKS = 2;

  logic              sync;
  bank_e             tag;
  stage_t            entry;
  logic              flush;
  bank_e             head_tag;
  logic              s_hit, d_hit;
  bank_e             d_tag;
  logic [DATA_W-1:0] s_data, d_data;
  logic [NBANKS-1:0] req;
  logic [DATA_W-1:0] wdat  [NBANKS];
  logic [DATA_W-1:0] bdat  [NBANKS];
  logic [NBANKS-1:0] bvld;

  sdm_steer u_steer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_p_i (sync_p_i),
    .sync_n_i (sync_n_i),
    .sync_o   (sync),
    .tag_o    (tag)
  );

  always_comb begin
    entry.vld  = 1'b1;
    entry.mode = single_mode_i;
    entry.tag  = tag;
    entry.data = {sample_hi_i, sample_lo_i};
  end

  sdm_pipe #(
    .NSTG  (NSTG),
    .TAP_S (TAP_S),
    .TAP_D (TAP_D)
  ) u_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .entry_i    (entry),
    .flush_o    (flush),
    .head_tag_o (head_tag),
    .s_hit_o    (s_hit),
    .s_data_o   (s_data),
    .d_hit_o    (d_hit),
    .d_tag_o    (d_tag),
    .d_data_o   (d_data)
  );

  // bank A takes the single tap or its dual turn; bank B only its dual turn
  always_comb begin
    req[0]  = s_hit | (d_hit & (d_tag == BANK_A));
    req[1]  = d_hit & (d_tag == BANK_B);
    wdat[0] = s_hit ? s_data : d_data;
    wdat[1] = d_data;
  end

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    sdm_bank u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (flush),
      .req_i   (req[b]),
      .data_i  (wdat[b]),
      .data_o  (bdat[b]),
      .valid_o (bvld[b])
    );
  end

  assign bank_a_o  = bdat[0];
  assign bank_b_o  = bdat[1];
  assign valid_a_o = bvld[0];
  assign valid_b_o = bvld[1];

  AST_ONE_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req)); // R4
  AST_B_HOLD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_hit && !flush) |=> $stable(bank_b_o)); // R3
  AST_SYNC_TO_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync |=> (head_tag == BANK_A)); // R6
  AST_FLUSH_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> (!valid_a_o && !valid_b_o)); // R9
endmodule

// File: tb/sim_sample_demux.sv
`timescale 1ns/1ps
module sim_sample_demux;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] hi = '0, lo = '0;
  logic       mode = 1'b1, sp = 1'b0, sn = 1'b1;
  logic [7:0] bank_a, bank_b;
  logic       va, vb;

  always #2.5 clk = ~clk;

  sample_demux u0 (
    .clk_i(clk), .rst_ni(rst_n), .sample_hi_i(hi), .sample_lo_i(lo),
    .single_mode_i(mode), .sync_p_i(sp), .sync_n_i(sn),
    .bank_a_o(bank_a), .bank_b_o(bank_b), .valid_a_o(va), .valid_b_o(vb)
  );

  typedef struct {
    int       due;
    bit       fl;
    bit       bk;
    bit [7:0] d;
  } ev_t;

  ev_t      q[$];
  int       cyc = 0;
  int       n_chk = 0, n_fail = 0;
  bit       done = 1'b0;
  bit       running = 1'b0;
  string    req = "R8";
  bit [7:0] exp_a = '0, exp_b = '0;
  bit       exp_va = 1'b0, exp_vb = 1'b0;
  bit       tog = 1'b0;
  bit       prev_mode = 1'b1;

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [7:0] act, input logic [7:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: got %0h expected %0h", r, what, cyc, act, expv);
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // driver: sets inputs at a negedge, records what the capture edge must produce
  task automatic drive(input logic [3:0] h, input logic [3:0] l, input bit m,
                       input bit p, input bit n);
    int e;
    bit tg;
    e  = cyc + 1;
    hi = h; lo = l; mode = m; sp = p; sn = n;
    if (m != prev_mode) begin
      // R9: in-flight samples dropped, no write on the change edge
      for (int i = q.size() - 1; i >= 0; i--) if (q[i].due >= e) q.delete(i);
      q.push_back('{due: e, fl: 1'b1, bk: 1'b0, d: 8'h00});
    end
    prev_mode = m;
    tg  = (p && !n) ? 1'b0 : tog;   // R6
    tog = ~tg;
    if (m) q.push_back('{due: e + 4, fl: 1'b0, bk: 1'b0, d: {h, l}});  // R2
    else   q.push_back('{due: e + 5, fl: 1'b0, bk: tg,   d: {h, l}});  // R5
    @(negedge clk);
  endtask

  // monitor: applies due events to the bank model and compares every cycle
  always @(negedge clk) begin
    if (running) begin
      while (q.size() > 0 && q[0].due <= cyc) begin
        if (q[0].due < cyc) chk(1'b0, req, "stale event", 8'(q[0].due), 8'(cyc));
        else if (q[0].fl) begin exp_va = 1'b0; exp_vb = 1'b0; end
        else if (q[0].bk == 1'b0) begin exp_a = q[0].d; exp_va = 1'b1; end
        else begin exp_b = q[0].d; exp_vb = 1'b1; end
        void'(q.pop_front());
      end
      chk(bank_a === exp_a, req, "bank_a", bank_a, exp_a);
      chk(bank_b === exp_b, req, "bank_b", bank_b, exp_b);
      chk(va === exp_va, req, "valid_a (R10)", {7'd0, va}, {7'd0, exp_va});
      chk(vb === exp_vb, req, "valid_b (R10)", {7'd0, vb}, {7'd0, exp_vb});
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired at cycle %0d: got hang expected finish", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(bank_a === 8'h00, "R8", "bank_a in reset", bank_a, 8'h00);
    chk(bank_b === 8'h00, "R8", "bank_b in reset", bank_b, 8'h00);
    chk(va === 1'b0, "R8", "valid_a in reset", {7'd0, va}, 8'h00);
    chk(vb === 1'b0, "R8", "valid_b in reset", {7'd0, vb}, 8'h00);
    rst_n = 1'b1;
    running = 1'b1;

    // R1 R2 R3: single mode, distinct nibbles, B untouched
    req = "R2";
    for (int i = 0; i < 10; i++) drive(4'(i + 1), 4'(14 - i), 1'b1, 1'b0, 1'b1);

    // R4 R5 R7 R9: dual mode without a strobe (flush on the change edge)
    req = "R5";
    for (int i = 0; i < 10; i++) drive(4'(i), 4'(i + 5), 1'b0, 1'b0, 1'b1);

    // R6: strobe, then non-strobe pairs 1/1, 0/0, 0/1, then back-to-back strobes
    req = "R6";
    drive(4'hA, 4'h1, 1'b0, 1'b1, 1'b0);
    drive(4'hA, 4'h2, 1'b0, 1'b1, 1'b1);
    drive(4'hA, 4'h3, 1'b0, 1'b0, 1'b0);
    drive(4'hA, 4'h4, 1'b0, 1'b0, 1'b1);
    drive(4'hA, 4'h5, 1'b0, 1'b1, 1'b0);
    drive(4'hA, 4'h6, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) drive(4'hB, 4'(i), 1'b0, 1'b0, 1'b1);

    // R9 with R6 on the same edge: single run, then dual entered with a strobe
    req = "R9";
    for (int i = 0; i < 6; i++) drive(4'hC, 4'(i), 1'b1, 1'b0, 1'b1);
    drive(4'hD, 4'h0, 1'b0, 1'b1, 1'b0);
    for (int i = 1; i < 9; i++) drive(4'hD, 4'(i), 1'b0, 1'b0, 1'b1);

    // R7: short mode bounces shorter than the latency
    req = "R7";
    drive(4'hE, 4'h1, 1'b1, 1'b0, 1'b1);
    drive(4'hE, 4'h2, 1'b0, 1'b0, 1'b1);
    drive(4'hE, 4'h3, 1'b1, 1'b0, 1'b1);

    // R3: single mode to drain, bank B must hold
    req = "R3";
    for (int i = 0; i < 12; i++) drive(4'h5, 4'(i), 1'b1, 1'b0, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule